// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Controller

This block gathers interrupt sources from a network interface controller into one 32-bit status word. Each source sets its own sticky bit. A host read returns the word and clears it in the same cycle. A mask register selects which set bits drive the single host interrupt line.

Sources arrive in several ways:
- single-cycle internal pulses;
- active-low external levels;
- comparisons across a parameterised set of buffer pools, each with a remaining-batch count and an alert threshold.

A mode input selects PCI or Generic behaviour; two host-bus error sources can fire only in Generic mode. An internal timer raises an initialisation-complete bit a fixed number of clocks after reset. Until that bit is set, host writes to the command register are refused and a blocked-access flag is raised.

Top module: `irq_status_ctrl`

## Requirements
- R1: A status bit, once set, stays 1 on every following cycle until a host status read occurs.
- R2: A cycle with `stat_rd` high clears every status bit at the next clock edge. During that cycle `stat_rdata` shows the value held before the clear.
- R3: An event present in the same cycle as a status read leaves its bit set after the clear. An event that repeats while its bit is already 1 leaves the bit at 1.
- R4: `irq` goes high one clock after a status bit and its mask bit (same position) are both 1. It stays low when no set bit is enabled.
- R5: While reset is active, the status word, mask, command register, `irq` and `cmd_blocked` are all 0.
- R6: Status bit 1 (PHY) is set by a high `phy_evt` or by a low `phy_int_n`.
- R7: Bit 6 (host-bus parity, from `hb_par_err`) and bit 7 (bus error, from a low `bus_err_n`) are set only when `mode_pci` is 0. With `mode_pci` at 1, neither bit is ever set.
- R8: Bit 2 is set when any pool's remaining count is strictly greater than its alert level. Bit 3 is set when any pool's remaining count equals 0.
- R9: Bit 0 (init complete) is set at exactly the INIT_CYCLES-th rising clock edge after reset is released, and not before.
- R10: A write with `hw_en`=1 and `hw_sel`=1 loads `cmd_rdata` only after init completes. Before that the write is ignored and `cmd_blocked` becomes 1 and stays 1.
- R11: A write with `hw_en`=1 and `hw_sel`=0 loads the mask register in any cycle, including during initialisation.
- R12: Bit 4 is receiver-stopped (`rx_stop_done`), bit 5 is control-memory parity (`cm_par_err`), and bits 31..8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pci | input | 1 | 1 = PCI mode, 0 = Generic mode |
| phy_evt | input | 1 | Internal PHY event pulse |
| phy_int_n | input | 1 | External PHY interrupt, active low |
| pool_left | input | NUM_POOLS*CNT_W | Remaining batch count per pool, packed |
| pool_alert_lvl | input | NUM_POOLS*CNT_W | Alert threshold per pool, packed |
| rx_stop_done | input | 1 | Receiver shutdown finished pulse |
| cm_par_err | input | 1 | Control-memory parity error pulse |
| hb_par_err | input | 1 | Host-bus parity error pulse |
| bus_err_n | input | 1 | External bus error, active low |
| stat_rd | input | 1 | Host status read strobe |
| stat_rdata | output | 32 | Status word |
| hw_en | input | 1 | Host write enable |
| hw_sel | input | 1 | Write target: 0 mask, 1 command |
| hw_wdata | input | 32 | Host write data |
| mask_rdata | output | 32 | Current interrupt mask |
| cmd_rdata | output | 32 | Current command register |
| cmd_blocked | output | 1 | Sticky flag for a refused command write |
| irq | output | 1 | Host interrupt line |

## Verification
The bench goes after a read that coincides with a new event. A design that clears unconditionally would lose that event's bit.

It also checks the cycle where the interrupt line lags the status word. A combinational or two-cycle path would show `irq` one cycle off.

Further checks cover:
- the exact edge where init completes; an off-by-one counter sets bit 0 a cycle early or late;
- a command write inside the init window, which a missing gate would accept;
- PCI mode with both host-bus error inputs active, where a missing gate sets bits 6 and 7;
- pool counts sitting exactly at the alert level and at zero, which catch a wrong comparison.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;

    localparam int STAT_W = 32;

    // status bit positions
    localparam int B_INIT   = 0;
    localparam int B_PHY    = 1;
    localparam int B_ALERT  = 2;
    localparam int B_EMPTY  = 3;
    localparam int B_RXSTOP = 4;
    localparam int B_CMPAR  = 5;
    localparam int B_HBPAR  = 6;
    localparam int B_BUSERR = 7;
    localparam int NUM_SRC  = 8;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_CMD  = 1'b1
    } hsel_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] mask;
        logic              irq;
    } core_st_t;

    typedef struct packed {
        logic [STAT_W-1:0] cmd;
        logic              blocked;
    } gate_st_t;

endpackage

// File: rtl/isr_init_timer.sv
`timescale 1ns/1ps
module isr_init_timer #(
    parameter int INIT_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_q,
    output logic done_rise
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_q    = st_q.done;
    assign done_rise = st_d.done & ~st_q.done;

    AST_INIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q); // R9
    AST_INIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (st_q.cnt <= LAST)); // R9

endmodule

// File: rtl/isr_event_map.sv
`timescale 1ns/1ps
module isr_event_map
    import isr_pkg::*;
#(
    parameter int NUM_POOLS = 4,
    parameter int CNT_W     = 8
) (
    input  logic                       mode_pci,
    input  logic                       phy_evt,
    input  logic                       phy_int_n,
    input  logic [NUM_POOLS*CNT_W-1:0] pool_left,
    input  logic [NUM_POOLS*CNT_W-1:0] pool_alert_lvl,
    input  logic                       rx_stop_done,
    input  logic                       cm_par_err,
    input  logic                       hb_par_err,
    input  logic                       bus_err_n,
    input  logic                       init_rise,
    output logic [STAT_W-1:0]          ev
);
    logic [NUM_POOLS-1:0] over_lvl;
    logic [NUM_POOLS-1:0] is_empty;
    logic                 generic_mode;

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        logic [CNT_W-1:0] left_p;
        logic [CNT_W-1:0] lvl_p;
        assign left_p      = pool_left[p*CNT_W +: CNT_W];
        assign lvl_p       = pool_alert_lvl[p*CNT_W +: CNT_W];
        assign over_lvl[p] = left_p > lvl_p;
        assign is_empty[p] = left_p == '0;
    end

    assign generic_mode = ~mode_pci;

    always_comb begin
        ev           = '0;
        ev[B_INIT]   = init_rise;
        ev[B_PHY]    = phy_evt | ~phy_int_n;
        ev[B_ALERT]  = |over_lvl;
        ev[B_EMPTY]  = |is_empty;
        ev[B_RXSTOP] = rx_stop_done;
        ev[B_CMPAR]  = cm_par_err;
        ev[B_HBPAR]  = generic_mode & hb_par_err;
        ev[B_BUSERR] = generic_mode & ~bus_err_n;
    end

endmodule

// File: rtl/isr_status_core.sv
`timescale 1ns/1ps
module isr_status_core
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev,
    input  logic              stat_rd,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_q
);
    core_st_t st_d, st_q;
    logic [STAT_W-1:0] kept;

    always_comb begin
        st_d     = st_q;
        kept     = stat_rd ? '0 : st_q.stat;
        st_d.stat = kept | ev;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        st_d.irq = |(st_q.stat & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign mask_q = st_q.mask;
    assign irq_q  = st_q.irq;

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev == '0) |=> (stat_q == '0)); // R2
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev))); // R3
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(stat_q != '0)); // R4
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata))); // R11

endmodule

// File: rtl/isr_cmd_gate.sv
`timescale 1ns/1ps
module isr_cmd_gate
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              cmd_we,
    input  logic [STAT_W-1:0] cmd_wdata,
    output logic [STAT_W-1:0] cmd_q,
    output logic              blocked_q
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_we) begin
            if (init_done) begin
                st_d.cmd = cmd_wdata;
            end else begin
                st_d.blocked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q     = st_q.cmd;
    assign blocked_q = st_q.blocked;

    AST_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && cmd_we) |=> ($stable(cmd_q) && blocked_q)); // R10
    AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_q |=> blocked_q); // R10

endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
    import isr_pkg::*;
#(
    parameter int NUM_POOLS   = 4,
    parameter int CNT_W       = 8,
    parameter int INIT_CYCLES = 32768
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_pci,
    input  logic                       phy_evt,
    input  logic                       phy_int_n,
    input  logic [NUM_POOLS*CNT_W-1:0] pool_left,
    input  logic [NUM_POOLS*CNT_W-1:0] pool_alert_lvl,
    input  logic                       rx_stop_done,
    input  logic                       cm_par_err,
    input  logic                       hb_par_err,
    input  logic                       bus_err_n,
    input  logic                       stat_rd,
    output logic [31:0]                stat_rdata,
    input  logic                       hw_en,
    input  logic                       hw_sel,
    input  logic [31:0]                hw_wdata,
    output logic [31:0]                mask_rdata,
    output logic [31:0]                cmd_rdata,
    output logic                       cmd_blocked,
    output logic                       irq
);
    logic              init_done;
    logic              init_rise;
    logic [STAT_W-1:0] ev;
    logic              mask_we;
    logic              cmd_we;

    assign mask_we = hw_en & (hw_sel == SEL_MASK);
    assign cmd_we  = hw_en & (hw_sel == SEL_CMD);

    isr_init_timer #(
        .INIT_CYCLES(INIT_CYCLES)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_q   (init_done),
        .done_rise(init_rise)
    );

    isr_event_map #(
        .NUM_POOLS(NUM_POOLS),
        .CNT_W    (CNT_W)
    ) i_evmap (
        .mode_pci      (mode_pci),
        .phy_evt       (phy_evt),
        .phy_int_n     (phy_int_n),
        .pool_left     (pool_left),
        .pool_alert_lvl(pool_alert_lvl),
        .rx_stop_done  (rx_stop_done),
        .cm_par_err    (cm_par_err),
        .hb_par_err    (hb_par_err),
        .bus_err_n     (bus_err_n),
        .init_rise     (init_rise),
        .ev            (ev)
    );

    isr_status_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .stat_rd   (stat_rd),
        .mask_we   (mask_we),
        .mask_wdata(hw_wdata),
        .stat_q    (stat_rdata),
        .mask_q    (mask_rdata),
        .irq_q     (irq)
    );

    isr_cmd_gate i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_done(init_done),
        .cmd_we   (cmd_we),
        .cmd_wdata(hw_wdata),
        .cmd_q    (cmd_rdata),
        .blocked_q(cmd_blocked)
    );

    AST_PCI_NO_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pci && stat_rd) |=> (stat_rdata[B_BUSERR:B_HBPAR] == 2'b00)); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[STAT_W-1:NUM_SRC] == '0); // R12
    AST_INIT_BIT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> stat_rdata[B_INIT]); // R9

endmodule

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
    localparam int NP   = 4;
    localparam int CW   = 8;
    localparam int INIT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic           b_mode_pci, b_phy_evt, b_phy_n, b_rx, b_cm, b_hb, b_err_n, b_rd;
    logic           b_hw_en, b_hw_sel;
    logic [31:0]    b_wdata;
    logic [CW-1:0]  b_left [NP];
    logic [CW-1:0]  b_lvl  [NP];
    logic [NP*CW-1:0] left_flat, lvl_flat;

    logic [31:0] stat_rdata, mask_rdata, cmd_rdata;
    logic        cmd_blocked, irq;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            left_flat[p*CW +: CW] = b_left[p];
            lvl_flat[p*CW +: CW]  = b_lvl[p];
        end
    end

    irq_status_ctrl #(.NUM_POOLS(NP), .CNT_W(CW), .INIT_CYCLES(INIT)) i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_pci(b_mode_pci), .phy_evt(b_phy_evt),
        .phy_int_n(b_phy_n), .pool_left(left_flat), .pool_alert_lvl(lvl_flat),
        .rx_stop_done(b_rx), .cm_par_err(b_cm), .hb_par_err(b_hb), .bus_err_n(b_err_n),
        .stat_rd(b_rd), .stat_rdata(stat_rdata), .hw_en(b_hw_en), .hw_sel(b_hw_sel),
        .hw_wdata(b_wdata), .mask_rdata(mask_rdata), .cmd_rdata(cmd_rdata),
        .cmd_blocked(cmd_blocked), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit finished = 0;
    logic [31:0] exp_stat = 0, exp_mask = 0, exp_cmd = 0;
    logic        exp_irq = 0, exp_blk = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic quiet();
        b_phy_evt = 0; b_phy_n = 1; b_rx = 0; b_cm = 0; b_hb = 0; b_err_n = 1;
        b_rd = 0; b_hw_en = 0; b_hw_sel = 0; b_wdata = 0;
        for (int p = 0; p < NP; p++) begin b_left[p] = 5; b_lvl[p] = 10; end
    endtask

    function automatic logic [31:0] exp_events();
        logic [31:0] e = 0;
        if (b_phy_evt || !b_phy_n) e[1] = 1;
        for (int p = 0; p < NP; p++) begin
            if (b_left[p] > b_lvl[p]) e[2] = 1;
            if (b_left[p] == 0) e[3] = 1;
        end
        if (b_rx) e[4] = 1;
        if (b_cm) e[5] = 1;
        if (!b_mode_pci && b_hb) e[6] = 1;
        if (!b_mode_pci && !b_err_n) e[7] = 1;
        if (cyc_n + 1 == INIT) e[0] = 1;
        return e;
    endfunction

    task automatic tick(input string tag);
        logic [31:0] ev, nstat;
        logic nirq;
        ev = exp_events();
        chk(tag, "rdata before edge", stat_rdata, exp_stat);
        nirq  = |(exp_stat & exp_mask);
        nstat = (b_rd ? 32'h0 : exp_stat) | ev;
        if (b_hw_en && !b_hw_sel) exp_mask = b_wdata;
        if (b_hw_en && b_hw_sel) begin
            if (cyc_n >= INIT) exp_cmd = b_wdata;
            else exp_blk = 1;
        end
        exp_stat = nstat;
        exp_irq  = nirq;
        @(posedge clk);
        #2;
        cyc_n++;
        chk(tag, "status", stat_rdata, exp_stat);
        chk(tag, "irq", {31'b0, irq}, {31'b0, exp_irq});
        chk(tag, "mask", mask_rdata, exp_mask);
        chk(tag, "cmd", cmd_rdata, exp_cmd);
        chk(tag, "blocked", {31'b0, cmd_blocked}, {31'b0, exp_blk});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd7));
        b_mode_pci = 0;
        quiet();
        repeat (3) @(posedge clk);
        #2;
        chk("R5", "reset status", stat_rdata, 0);
        chk("R5", "reset irq", {31'b0, irq}, 0);
        chk("R5", "reset cmd", cmd_rdata, 0);
        chk("R5", "reset blocked", {31'b0, cmd_blocked}, 0);
        chk("R5", "reset mask", mask_rdata, 0);
        rst_n = 1;

        repeat (4) tick("R9");
        // R11: mask writable during init
        b_hw_en = 1; b_hw_sel = 0; b_wdata = 32'h0000_0030;
        tick("R11");
        chk("R11", "mask during init", mask_rdata, 32'h30);
        // R10: command write refused during init
        b_hw_sel = 1; b_wdata = 32'hA5A5_0001;
        tick("R10");
        quiet();
        chk("R10", "cmd unchanged", cmd_rdata, 0);
        chk("R10", "blocked set", {31'b0, cmd_blocked}, 1);
        while (cyc_n < INIT - 1) tick("R9");
        chk("R9", "init bit early", {31'b0, stat_rdata[0]}, 0);
        tick("R9");
        chk("R9", "init bit at edge", {31'b0, stat_rdata[0]}, 1);

        b_hw_en = 1; b_hw_sel = 1; b_wdata = 32'hC0DE_0042;
        tick("R10");
        quiet();
        chk("R10", "cmd accepted", cmd_rdata, 32'hC0DE_0042);

        b_rd = 1;
        chk("R2", "rdata pre-clear", stat_rdata, 32'h1);
        tick("R2");
        quiet();
        chk("R2", "cleared", stat_rdata, 0);

        // R4 / R1: rx event with mask bit 4 set
        b_rx = 1;
        tick("R4");
        quiet();
        chk("R4", "irq lags status", {31'b0, irq}, 0);
        tick("R4");
        chk("R4", "irq asserted", {31'b0, irq}, 1);
        repeat (3) tick("R1");
        chk("R1", "bit held", stat_rdata, 32'h10);
        // R3: read collides with cm parity event
        b_rd = 1; b_cm = 1;
        tick("R3");
        quiet();
        chk("R3", "event survives clear", stat_rdata, 32'h20);
        b_cm = 1;
        tick("R3");
        quiet();
        chk("R3", "repeat keeps bit", stat_rdata, 32'h20);
        b_rd = 1; tick("R2"); quiet();

        // R6
        b_phy_n = 0; tick("R6"); quiet();
        chk("R6", "ext phy low", stat_rdata, 32'h2);
        b_rd = 1; tick("R6"); quiet();
        b_phy_evt = 1; tick("R6"); quiet();
        chk("R6", "int phy pulse", stat_rdata, 32'h2);
        b_rd = 1; tick("R6"); quiet();

        // R7
        b_mode_pci = 1; b_hb = 1; b_err_n = 0;
        tick("R7");
        chk("R7", "pci suppresses", stat_rdata, 0);
        b_mode_pci = 0;
        tick("R7");
        quiet();
        chk("R7", "generic sets", stat_rdata, 32'hC0);
        b_rd = 1; tick("R7"); quiet();

        // R8: equal level is no alert, above level is
        b_left[1] = 10; b_lvl[1] = 10;
        tick("R8");
        chk("R8", "equal no alert", stat_rdata, 0);
        b_left[1] = 11;
        tick("R8");
        chk("R8", "above level alert", stat_rdata, 32'h4);
        quiet();
        b_rd = 1; tick("R8"); quiet();
        b_left[2] = 0;
        tick("R8");
        quiet();
        chk("R8", "empty pool", stat_rdata, 32'h8);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            b_phy_evt = ($urandom % 8) == 0;
            b_phy_n   = ($urandom % 16) != 0;
            b_rx      = ($urandom % 8) == 0;
            b_cm      = ($urandom % 8) == 0;
            b_hb      = ($urandom % 8) == 0;
            b_err_n   = ($urandom % 8) != 0;
            b_rd      = ($urandom % 4) == 0;
            if (($urandom % 32) == 0) b_mode_pci = ~b_mode_pci;
            b_hw_en   = ($urandom % 8) == 0;
            b_hw_sel  = 1'($urandom % 2);
            b_wdata   = $urandom;
            for (int p = 0; p < NP; p++) begin
                b_left[p] = CW'($urandom % 24);
                b_lvl[p]  = CW'($urandom % 24);
            end
            tick("R1 R2 R3 R4 R6 R7 R8 R11 R12");
            chk("R12", "upper bits zero", {8'b0, stat_rdata[31:8]}, 0);
        end
        summary();
    end
endmodule